// File: doc/BRIEF.md
# Abortable Shift-Add Multiplier

This block computes the low 32 bits of the product of two 32-bit operands with a single adder. It works on one bit of the second operand per clock. A request is taken from an idle block when a start strobe arrives with both operands. The block then stays busy for a fixed 32 cycles and finishes with a one-cycle done pulse that marks a new result word. The partial product is never widened past 32 bits, so the area is one adder and a few 32-bit registers. It gives the same word as a full single-cycle array multiplier.

An abort input, normally driven by a pending-interrupt request, cancels a running operation on the next clock edge. The busy flag drops at once and no done pulse follows. The last completed result stays on the output. Partial progress is not kept: the caller reissues the multiply later, and it starts again from the first iteration.

Top module: `shiftadd_mul`

## Requirements
- R1: While reset is asserted and after it is released, `busy_o` and `done_o` are 0 and `product_o` is 0 until the first multiply completes.
- R2: When the block is idle (`busy_o` = 0) and `start_i` = 1 with `abort_i` = 0 at a clock edge, the block captures `op_a_i` and `op_b_i` and raises `busy_o` after that edge.
- R3: The completed `product_o` equals bits 31:0 of the unsigned product of the two captured operands. Operands read as two's-complement give the same word.
- R4: `busy_o` stays high for exactly 32 cycles after the accepting edge. On the 32nd edge `busy_o` falls, and `done_o` is 1 for exactly that one following cycle.
- R5: `product_o` changes only on the edge that raises `done_o`; otherwise it holds its value.
- R6: `start_i` asserted while `busy_o` = 1 and `abort_i` = 0 is ignored. The running operation completes on its original schedule with its original result.
- R7: `abort_i` = 1 while `busy_o` = 1 clears `busy_o` after the next edge. No `done_o` pulse is produced for that operation and `product_o` is unchanged. This includes an abort on the final iteration.
- R8: When `start_i` and `abort_i` are both 1 at the same edge, abort wins and the block is idle after that edge.
- R9: A multiply issued after an abort runs the full 32 cycles from the first iteration and yields the correct product of its own operands.
- R10: `done_o` is never 1 while `busy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| start_i | input | 1 | Request a multiply; taken only when idle and not aborting |
| op_a_i | input | 32 | Multiplicand, sampled on the accepting edge |
| op_b_i | input | 32 | Multiplier, sampled on the accepting edge |
| abort_i | input | 1 | Abandon the running multiply (pending-interrupt request) |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle pulse: a new result is on `product_o` |
| product_o | output | 32 | Low 32 bits of the last completed product |

## Verification
A stuck or skipped iteration count shows at the ports as a busy window that is not 32 cycles long. The checker catches it on the done edge. A wrong bit selection or adder input shows only in the result word, so the bench compares every completed product against an independently computed one. A gate on the abort path that leaks shows on the very next edge, as a busy flag still high or a stray done pulse. Partial state kept across an abort shows as a wrong word or a wrong latency on the reissued operation.

// File: rtl/shiftadd_mul_pkg.sv
package shiftadd_mul_pkg;

  typedef enum logic {
    SAM_IDLE = 1'b0,
    SAM_RUN  = 1'b1
  } sam_state_e;

endpackage

// File: rtl/sam_iter_cnt.sv
module sam_iter_cnt #(
  parameter int ITERS = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic step_i,
  output logic last_o
);
  localparam int CW = (ITERS > 1) ? $clog2(ITERS) : 1;
  localparam logic [CW-1:0] LAST_VAL = CW'(ITERS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = clear_i | step_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i) begin
      cnt_d = '0;
    end else if (step_i) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign last_o = (cnt_q == LAST_VAL);

endmodule

// File: rtl/sam_ctrl.sv
module sam_ctrl
  import shiftadd_mul_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  input  logic last_i,
  output logic load_o,
  output logic step_o,
  output logic finish_o,
  output logic busy_o
);
  sam_state_e state_q, state_d;

  // abort gates every state-changing action
  assign load_o   = (state_q == SAM_IDLE) & start_i & ~abort_i;
  assign step_o   = (state_q == SAM_RUN) & ~abort_i;
  assign finish_o = step_o & last_i;
  assign busy_o   = (state_q == SAM_RUN);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SAM_IDLE: if (load_o) state_d = SAM_RUN;
      SAM_RUN:  if (abort_i || finish_o) state_d = SAM_IDLE;
      default:  state_d = SAM_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SAM_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/sam_datapath.sv
module sam_datapath #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [WIDTH-1:0] op_a_i,
  input  logic [WIDTH-1:0] op_b_i,
  output logic [WIDTH-1:0] acc_next_o
);
  logic [WIDTH-1:0] mcand_q, mcand_d;
  logic [WIDTH-1:0] mplier_q, mplier_d;
  logic [WIDTH-1:0] acc_q, acc_d;
  logic [WIDTH-1:0] addend;
  logic             reg_en;

  // partial product: multiplicand gated by the current multiplier bit
  for (genvar i = 0; i < WIDTH; i++) begin : g_pp
    assign addend[i] = mcand_q[i] & mplier_q[0];
  end

  assign acc_next_o = acc_q + addend;
  assign reg_en     = load_i | step_i;

  always_comb begin
    mcand_d  = mcand_q;
    mplier_d = mplier_q;
    acc_d    = acc_q;
    if (load_i) begin
      mcand_d  = op_a_i;
      mplier_d = op_b_i;
      acc_d    = '0;
    end else if (step_i) begin
      mcand_d  = {mcand_q[WIDTH-2:0], 1'b0};
      mplier_d = {1'b0, mplier_q[WIDTH-1:1]};
      acc_d    = acc_next_o;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      acc_q    <= '0;
    end else if (reg_en) begin
      mcand_q  <= mcand_d;
      mplier_q <= mplier_d;
      acc_q    <= acc_d;
    end
  end

endmodule

// File: rtl/shiftadd_mul.sv
module shiftadd_mul #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] op_a_i,
  input  logic [WIDTH-1:0] op_b_i,
  input  logic             abort_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] product_o
);
  localparam int ITERS = WIDTH;

  logic             load, step, finish, last_iter;
  logic [WIDTH-1:0] acc_next;
  logic [WIDTH-1:0] result_q, result_d;
  logic             done_q;

  sam_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .abort_i  (abort_i),
    .last_i   (last_iter),
    .load_o   (load),
    .step_o   (step),
    .finish_o (finish),
    .busy_o   (busy_o)
  );

  sam_iter_cnt #(.ITERS(ITERS)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (load),
    .step_i  (step),
    .last_o  (last_iter)
  );

  sam_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .step_i     (step),
    .op_a_i     (op_a_i),
    .op_b_i     (op_b_i),
    .acc_next_o (acc_next)
  );

  assign result_d = acc_next;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
    end else if (finish) begin
      result_q <= result_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
    end
  end

  assign done_o    = done_q;
  assign product_o = result_q;

endmodule

// File: rtl/sam_checker.sv
module sam_checker #(
  parameter int WIDTH = 32,
  parameter int ITERS = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             abort_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [WIDTH-1:0] product_o
);
  localparam int LW = $clog2(ITERS + 2) + 1;
  logic [LW-1:0] run_len;

  // length of the current busy window, counted independently of the design
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_len <= '0;
    end else if (busy_o) begin
      run_len <= run_len + LW'(1);
    end else begin
      run_len <= '0;
    end
  end

  p_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && !abort_i) |=> busy_o);

  p_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (run_len == LW'(ITERS)));

  p_single_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_busy_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (run_len < LW'(ITERS)));

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(product_o));

  p_abort_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && abort_i) |=> (!busy_o && !done_o));

  p_abort_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && abort_i) |=> (!busy_o && !done_o));

  p_exclusive_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && busy_o));

endmodule

bind shiftadd_mul sam_checker #(.WIDTH(WIDTH), .ITERS(ITERS)) u_sam_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .abort_i   (abort_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .product_o (product_o)
);

// File: tb/shiftadd_mul_bench.sv
module shiftadd_mul_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int N = 32;
  localparam int WATCHDOG = 100000;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic         abort;
  logic [W-1:0] a, b;
  logic         busy, done;
  logic [W-1:0] prod;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  shiftadd_mul #(.WIDTH(W)) u_shiftadd_mul (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .start_i   (start),
    .op_a_i    (a),
    .op_b_i    (b),
    .abort_i   (abort),
    .busy_o    (busy),
    .done_o    (done),
    .product_o (prod)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !finished) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual cycles=%0d expected <= %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [W-1:0] ref_mul(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [2*W-1:0] full;
    full = {{W{1'b0}}, x} * {{W{1'b0}}, y};
    return full[W-1:0];
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // drive a request at a falling edge, return at the falling edge after the accepting edge
  task automatic issue(input logic [W-1:0] x, input logic [W-1:0] y);
    start = 1'b1; a = x; b = y;
    edges(1);
    start = 1'b0; a = '0; b = '0;
  endtask

  // full operation with timing checks
  task automatic run_full(input string tag, input logic [W-1:0] x, input logic [W-1:0] y);
    issue(x, y);
    check({tag, " R2 busy after accept"}, W'(busy), W'(1));
    edges(N - 1);
    check({tag, " R4 busy before last iteration"}, W'(busy), W'(1));
    check({tag, " R4 no early done"}, W'(done), W'(0));
    edges(1);
    check({tag, " R4 done on 32nd edge"}, W'(done), W'(1));
    check({tag, " R10 busy low at done"}, W'(busy), W'(0));
    check({tag, " R3 product"}, prod, ref_mul(x, y));
    edges(1);
    check({tag, " R4 done one cycle only"}, W'(done), W'(0));
    check({tag, " R5 product held"}, prod, ref_mul(x, y));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; abort = 1'b0; a = '0; b = '0;
    edges(3);
    check("R1 busy in reset", W'(busy), W'(0));
    check("R1 done in reset", W'(done), W'(0));
    check("R1 product in reset", prod, '0);
    rst_n = 1'b1;
    edges(2);
    check("R1 busy after reset", W'(busy), W'(0));
    check("R1 product after reset", prod, '0);
  endtask

  task automatic t_patterns();
    run_full("pat1", 32'd12345, 32'd6789);
    run_full("pat2", 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_full("pat3", 32'hDEAD_BEEF, 32'h0000_0000);
    run_full("pat4", 32'h8000_0000, 32'h0000_0003);
    run_full("pat5", 32'hFFFF_FFFD, 32'd7);  // -3 * 7, R3 signed view
    check("R3 signed view", prod, 32'hFFFF_FFEB);
    run_full("pat6", 32'h1234_5678, 32'h9ABC_DEF1);
  endtask

  task automatic t_start_while_busy();
    logic [W-1:0] old;
    issue(32'd1000, 32'd3000);
    edges(9);
    start = 1'b1; a = 32'd7; b = 32'd9;
    edges(1);
    start = 1'b0;
    // 10 edges consumed after accept, 22 remain
    edges(N - 11);
    check("R6 still busy on original schedule", W'(busy), W'(1));
    edges(1);
    check("R6 done on original schedule", W'(done), W'(1));
    check("R6 original result", prod, ref_mul(32'd1000, 32'd3000));
    old = prod;
    edges(N + 4);
    check("R6 no second operation", W'(busy), W'(0));
    check("R5 held while idle", prod, old);
  endtask

  task automatic t_abort_mid();
    logic [W-1:0] old;
    int seen;
    old = prod;
    issue(32'hCAFE_0001, 32'h0BAD_F00D);
    edges(12);
    abort = 1'b1;
    edges(1);
    abort = 1'b0;
    check("R7 busy drops after abort", W'(busy), W'(0));
    seen = 0;
    for (int i = 0; i < N + 8; i++) begin
      if (done) seen++;
      edges(1);
    end
    check("R7 no done for aborted op", W'(seen), W'(0));
    check("R7 product unchanged", prod, old);
    run_full("R9 reissue", 32'hCAFE_0001, 32'h0BAD_F00D);
  endtask

  task automatic t_abort_last();
    logic [W-1:0] old;
    int seen;
    old = prod;
    issue(32'd55, 32'd66);
    edges(N - 1);
    abort = 1'b1;
    edges(1);
    abort = 1'b0;
    check("R7 final-iteration abort busy", W'(busy), W'(0));
    check("R7 final-iteration abort done", W'(done), W'(0));
    seen = 0;
    for (int i = 0; i < 4; i++) begin
      if (done) seen++;
      edges(1);
    end
    check("R7 final-iteration no late done", W'(seen), W'(0));
    check("R7 final-iteration product", prod, old);
    run_full("R9 after final abort", 32'd55, 32'd66);
  endtask

  task automatic t_start_abort_same();
    logic [W-1:0] old;
    old = prod;
    start = 1'b1; abort = 1'b1; a = 32'd3; b = 32'd4;
    edges(1);
    start = 1'b0; abort = 1'b0;
    check("R8 idle after start+abort", W'(busy), W'(0));
    edges(N + 2);
    check("R8 no done", W'(done), W'(0));
    check("R8 product unchanged", prod, old);
    // busy block: start and abort together also end the operation
    issue(32'd11, 32'd13);
    edges(5);
    start = 1'b1; abort = 1'b1; a = 32'd2; b = 32'd2;
    edges(1);
    start = 1'b0; abort = 1'b0;
    check("R8 busy start+abort ends op", W'(busy), W'(0));
    edges(N + 2);
    check("R8 product after busy start+abort", prod, old);
  endtask

  initial begin
    t_reset();
    t_patterns();
    t_start_while_busy();
    t_abort_mid();
    t_abort_last();
    t_start_abort_same();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule